// File: doc/BRIEF.md
# Ethernet Address Lookup Table Engine

This block holds the address table of a small three-port Ethernet switch and turns a destination MAC address into a set of egress ports. Each table entry is a 69-bit record. It holds an entry type, a 48-bit MAC address, and either unicast attributes with a port number or multicast attributes with a port mask. The entries sit in an inferred block RAM. Software builds an entry in three 32-bit staging words and commits it by index. It reads an entry back by loading it into the same staging words.

A lookup request carries a destination MAC and the port the frame arrived on. The engine walks the table one index per cycle from index 0 and stops at the first matching address entry. If it reaches the end, the lookup is a miss. It then returns a port mask. The mask is limited to ports whose control register is in the forwarding state, and the source port is always removed. A clear command walks every index and frees it. While the clear runs, no lookup is accepted. The VLAN-aware bit is stored and read back but has no effect on lookups.

Top module: `lkt_engine`

## Requirements
- R1: After reset the control register reads 0, every port control register reads 0 (disabled), lk_done is low and lk_ready is high.
- R2: Entry bits are mapped to the staging words as follows: offset 0x34 holds entry bits 68:64 in its bits 4:0 and reads zero above, offset 0x38 holds bits 63:32, and offset 0x3C holds bits 31:0. Writing N with bit 31 set to offset 0x20 stores the staging words into entry N. Writing N with bit 31 clear loads entry N into the staging words, readable two cycles later.
- R3: In the control register at offset 0x08, bit 31 enables lookups and bit 2 is a stored VLAN-aware flag. Both read back as written, and all other bits read zero except bit 30.
- R4: The port control register of port p is at offset 0x40+4*p. It holds a two-bit state in bits 1:0 (0 disabled, 1 blocked, 2 learning, 3 forwarding), and upper write bits are dropped.
- R5: Writing 1 to control bit 30 starts a clear that writes an all-zero entry (type 0 = free) to every index, one per cycle. Bit 30 reads 1 and lk_ready is low while the clear runs, and bit 30 returns to 0 by itself when the clear ends.
- R6: Only entries whose type field (bits 61:60) is 1 (address) or 3 (VLAN plus address) and whose bits 47:0 equal the request MAC match. A unicast hit (bit 40 clear) that is not blocked (bit 65 clear) gives the one-hot mask of the port number in bits 67:66.
- R7: A unicast hit whose blocked bit 65 is set returns an empty mask.
- R8: A multicast hit (entry bit 40 set) returns the port mask in bits 68:66, where bit 66+p stands for port p.
- R9: Every returned mask holds only ports in the forwarding state and never the source port. A miss returns all forwarding ports except the source.
- R10: A request accepted while control bit 31 is 0 completes on the next cycle with an empty mask.
- R11: When several entries match, the one with the lowest index decides the result.
- R12: lk_ready is low from the cycle after a request is accepted until after its result. lk_done is a one-cycle pulse that carries lk_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request, taken when lk_ready is high |
| lk_mac | input | 48 | Destination MAC, first octet in bits 47:40 |
| lk_src | input | 2 | Ingress port number |
| lk_ready | output | 1 | Engine can take a request this cycle |
| lk_done | output | 1 | One-cycle result strobe |
| lk_mask | output | 3 | Egress port mask, bit p for port p |

## Verification
The assertions rely on the requester. lk_req is raised only while lk_ready is high. The enable bit and the port states are not rewritten while a lookup is in flight. Table control and staging words are not written during a clear or a lookup. The bench follows these rules. It waits for lk_ready before each request, changes port states and the enable bit only between lookups, and polls the clear bit before touching the table again. Within these rules it sweeps all 64 port-state combinations against every source port and every kind of table hit and miss.

// File: rtl/lkt_pkg.sv
package lkt_pkg;
  localparam int NPORT   = 3;
  localparam int ENTRY_W = 69;
  localparam int MAC_W   = 48;

  localparam logic [7:0] A_CTRL   = 8'h08;
  localparam logic [7:0] A_TBLCTL = 8'h20;
  localparam logic [7:0] A_WORD0  = 8'h34;
  localparam logic [7:0] A_WORD1  = 8'h38;
  localparam logic [7:0] A_WORD2  = 8'h3C;
  localparam logic [7:0] A_PORT0  = 8'h40;

  typedef enum logic [1:0] {
    ET_FREE = 2'd0, ET_ADDR = 2'd1, ET_VLAN = 2'd2, ET_VLAN_ADDR = 2'd3
  } etype_e;

  typedef enum logic [1:0] {
    PS_OFF = 2'd0, PS_BLOCK = 2'd1, PS_LEARN = 2'd2, PS_FWD = 2'd3
  } pstate_e;

  typedef logic [ENTRY_W-1:0] entry_t;

  function automatic etype_e f_type(entry_t e);
    return etype_e'(e[61:60]);
  endfunction

  function automatic logic [MAC_W-1:0] f_mac(entry_t e);
    return e[47:0];
  endfunction

  function automatic logic f_is_mc(entry_t e);
    return e[40];
  endfunction

  function automatic logic f_uc_blocked(entry_t e);
    return e[65];
  endfunction

  function automatic logic [1:0] f_uc_port(entry_t e);
    return e[67:66];
  endfunction

  function automatic logic [NPORT-1:0] f_mc_mask(entry_t e);
    return e[68:66];
  endfunction

  function automatic logic [NPORT-1:0] port_onehot(logic [1:0] p);
    logic [NPORT-1:0] o;
    o = '0;
    for (int i = 0; i < NPORT; i++)
      if (p == 2'(i)) o[i] = 1'b1;
    return o;
  endfunction
endpackage

// File: rtl/lkt_table_ram.sv
module lkt_table_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 69,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lkt_search.sv
module lkt_search
  import lkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [MAC_W-1:0] req_mac,
  input  logic [1:0]       req_src,
  input  logic             en,
  input  logic [NPORT-1:0] fwd,
  input  logic             clearing,
  input  logic             port_taken,
  output logic [IW-1:0]    rd_addr,
  input  entry_t           rd_data,
  output logic             ready,
  output logic             done,
  output logic [NPORT-1:0] mask
);
  typedef enum logic {S_IDLE, S_SCAN} st_e;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  st_e              st;
  logic [MAC_W-1:0] mac_q;
  logic [1:0]       src_q;
  logic [IW-1:0]    idx;
  logic             idx_end, cmp_v, cmp_last;
  logic             issue, hit, finish;
  etype_e           ty;
  logic [NPORT-1:0] base, src_bit, result;
  logic             unused_bits;

  assign unused_bits = ^{rd_data[59:48], rd_data[64:62]};
  assign rd_addr = idx;
  assign ready   = (st == S_IDLE) && !done && !clearing;
  assign issue   = (st == S_SCAN) && !idx_end && !clearing && !port_taken;

  always_comb begin
    ty  = f_type(rd_data);
    hit = cmp_v && (ty == ET_ADDR || ty == ET_VLAN_ADDR) && (f_mac(rd_data) == mac_q);
    if (!hit)                       base = '1;
    else if (f_is_mc(rd_data))      base = f_mc_mask(rd_data);
    else if (f_uc_blocked(rd_data)) base = '0;
    else                            base = port_onehot(f_uc_port(rd_data));
    src_bit = port_onehot(src_q);
    result  = base & fwd & ~src_bit;
    finish  = cmp_v && (hit || cmp_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mac_q    <= '0;
      src_q    <= '0;
      idx      <= '0;
      idx_end  <= 1'b0;
      cmp_v    <= 1'b0;
      cmp_last <= 1'b0;
      done     <= 1'b0;
      mask     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          cmp_v <= 1'b0;
          if (req && ready) begin
            if (!en) begin
              done <= 1'b1;
              mask <= '0;
            end else begin
              st      <= S_SCAN;
              mac_q   <= req_mac;
              src_q   <= req_src;
              idx     <= '0;
              idx_end <= 1'b0;
            end
          end
        end
        default: begin
          cmp_v    <= issue;
          cmp_last <= (idx == LAST);
          if (issue) begin
            idx <= idx + 1'b1;
            if (idx == LAST) idx_end <= 1'b1;
          end
          if (finish) begin
            done  <= 1'b1;
            mask  <= result;
            st    <= S_IDLE;
            cmp_v <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (req && ready) |=> !ready); // R12
  AST_SRC_EXCLUDED: assert property (@(posedge clk) disable iff (rst) done |-> ((mask & port_onehot(src_q)) == '0)); // R9
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (rst) (req && ready && !en) |=> (done && mask == '0)); // R10
  AST_CLEAR_STALL: assert property (@(posedge clk) disable iff (rst) clearing |-> !ready); // R5
endmodule

// File: rtl/lkt_engine.sv
module lkt_engine
  import lkt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             lk_req,
  input  logic [MAC_W-1:0] lk_mac,
  input  logic [1:0]       lk_src,
  output logic             lk_ready,
  output logic             lk_done,
  output logic [NPORT-1:0] lk_mask
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic             eng_en, vlan_aware, clr_busy, rd_pend, rd_fill;
  logic [IW-1:0]    clr_idx, tbl_idx, srch_addr;
  entry_t           stage, mem_wdata, mem_q;
  logic             mem_we;
  logic [IW-1:0]    mem_waddr, mem_raddr;
  pstate_e          pst [NPORT];
  logic [NPORT-1:0] fwd;
  logic [31:0]      rd_val;
  logic             wr_ctrl, wr_tbl, wr_w0, wr_w1, wr_w2;

  assign wr_ctrl = reg_wr && (reg_addr == AW'(A_CTRL));
  assign wr_tbl  = reg_wr && (reg_addr == AW'(A_TBLCTL));
  assign wr_w0   = reg_wr && (reg_addr == AW'(A_WORD0));
  assign wr_w1   = reg_wr && (reg_addr == AW'(A_WORD1));
  assign wr_w2   = reg_wr && (reg_addr == AW'(A_WORD2));

  always_comb begin
    mem_we    = clr_busy || (wr_tbl && reg_wdata[31]);
    mem_waddr = clr_busy ? clr_idx : reg_wdata[IW-1:0];
    mem_wdata = clr_busy ? '0 : stage;
    mem_raddr = rd_pend ? tbl_idx : srch_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_en     <= 1'b0;
      vlan_aware <= 1'b0;
      clr_busy   <= 1'b0;
      clr_idx    <= '0;
      tbl_idx    <= '0;
      rd_pend    <= 1'b0;
      rd_fill    <= 1'b0;
      stage      <= '0;
    end else begin
      rd_fill <= rd_pend;
      rd_pend <= 1'b0;
      if (rd_fill) stage <= mem_q;
      if (wr_ctrl) begin
        eng_en     <= reg_wdata[31];
        vlan_aware <= reg_wdata[2];
      end
      if (clr_busy) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == LAST) clr_busy <= 1'b0;
      end else if (wr_ctrl && reg_wdata[30]) begin
        clr_busy <= 1'b1;
        clr_idx  <= '0;
      end
      if (wr_tbl && !reg_wdata[31]) begin
        rd_pend <= 1'b1;
        tbl_idx <= reg_wdata[IW-1:0];
      end
      if (wr_w0) stage[68:64] <= reg_wdata[4:0];
      if (wr_w1) stage[63:32] <= reg_wdata;
      if (wr_w2) stage[31:0]  <= reg_wdata;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = reg_wr && (reg_addr == AW'(int'(A_PORT0) + 4 * p));
    always_ff @(posedge clk) begin
      if (rst)      pst[p] <= PS_OFF;
      else if (sel) pst[p] <= pstate_e'(reg_wdata[1:0]);
    end
    assign fwd[p] = (pst[p] == PS_FWD);
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == AW'(A_CTRL))   rd_val = {eng_en, clr_busy, 27'b0, vlan_aware, 2'b0};
    if (reg_addr == AW'(A_TBLCTL)) rd_val = {{(32-IW){1'b0}}, tbl_idx};
    if (reg_addr == AW'(A_WORD0))  rd_val = {27'b0, stage[68:64]};
    if (reg_addr == AW'(A_WORD1))  rd_val = stage[63:32];
    if (reg_addr == AW'(A_WORD2))  rd_val = stage[31:0];
    for (int p = 0; p < NPORT; p++)
      if (reg_addr == AW'(int'(A_PORT0) + 4 * p)) rd_val = {30'b0, pst[p]};
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  lkt_table_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W), .IW(IW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  lkt_search #(.DEPTH(DEPTH), .IW(IW)) u_srch (
    .clk(clk), .rst(rst), .req(lk_req), .req_mac(lk_mac), .req_src(lk_src),
    .en(eng_en), .fwd(fwd), .clearing(clr_busy), .port_taken(rd_pend),
    .rd_addr(srch_addr), .rd_data(mem_q),
    .ready(lk_ready), .done(lk_done), .mask(lk_mask)
  );

  AST_FWD_ONLY: assert property (@(posedge clk) disable iff (rst) lk_done |-> ((lk_mask & ~fwd) == '0)); // R9
  AST_REQ_WHEN_READY: assert property (@(posedge clk) disable iff (rst) lk_req |-> lk_ready); // R12
  AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (rst) (clr_busy && clr_idx == LAST) |=> !clr_busy); // R5
endmodule

// File: tb/sim_lkt_engine.sv
module sim_lkt_engine;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        lk_req = 1'b0;
  logic [47:0] lk_mac = '0;
  logic [1:0]  lk_src = '0;
  logic        lk_ready, lk_done;
  logic [2:0]  lk_mask;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lkt_engine #(.DEPTH(DEPTH), .AW(8)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_mac(lk_mac),
    .lk_src(lk_src), .lk_ready(lk_ready), .lk_done(lk_done), .lk_mask(lk_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic put_entry(input int idx, input logic [68:0] e);
    wr(8'h34, {27'b0, e[68:64]});
    wr(8'h38, e[63:32]);
    wr(8'h3C, e[31:0]);
    wr(8'h20, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic get_entry(input int idx, output logic [31:0] w0, w1, w2);
    wr(8'h20, 32'(idx));
    repeat (2) @(negedge clk);
    rd(8'h34, w0);
    rd(8'h38, w1);
    rd(8'h3C, w2);
  endtask

  task automatic wait_clear();
    logic [31:0] v;
    int n = 0;
    rd(8'h08, v);
    while (v[30] && n < 100) begin rd(8'h08, v); n++; end
  endtask

  task automatic lookup(input logic [47:0] mac, input int src, output logic [2:0] m);
    int n = 0;
    while (!lk_ready) @(negedge clk);
    lk_req = 1'b1; lk_mac = mac; lk_src = 2'(src);
    @(negedge clk);
    lk_req = 1'b0;
    chk("R12 ready low after accept", 32'(lk_ready), 32'd0);
    while (!lk_done && n < 100) begin @(negedge clk); n++; end
    chk("R12 done seen", 32'(lk_done), 32'd1);
    m = lk_mask;
    @(negedge clk);
    chk("R12 done is one pulse", 32'(lk_done), 32'd0);
  endtask

  function automatic logic [68:0] mk_uc(logic [47:0] mac, int port, bit blk, logic [1:0] typ);
    logic [68:0] e = '0;
    e[47:0] = mac; e[61:60] = typ; e[64] = 1'b1; e[65] = blk; e[67:66] = 2'(port);
    return e;
  endfunction

  function automatic logic [68:0] mk_mc(logic [47:0] mac, logic [2:0] pm, logic [1:0] typ);
    logic [68:0] e = '0;
    e[47:0] = mac; e[61:60] = typ; e[63:62] = 2'd3; e[68:66] = pm;
    return e;
  endfunction

  // kind: 0 miss, 1 unicast, 2 blocked unicast, 3 multicast
  function automatic logic [2:0] exp_mask(int kind, int port, logic [2:0] pm, logic [2:0] fw, int src);
    logic [2:0] b;
    case (kind)
      1: b = 3'(1 << port);
      2: b = 3'b000;
      3: b = pm;
      default: b = 3'b111;
    endcase
    return b & fw & ~3'(1 << src);
  endfunction

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_01;
  localparam logic [47:0] MAC_B = 48'h02_11_22_33_44_02;
  localparam logic [47:0] MAC_C = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] MAC_D = 48'h02_11_22_33_44_04;
  localparam logic [47:0] MAC_E = 48'h02_11_22_33_44_05;
  localparam logic [47:0] MAC_F = 48'h02_11_22_33_44_06;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w0, w1, w2;
    logic [2:0] m;
    logic [2:0] fw;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 ready", 32'(lk_ready), 32'd1);
    chk("R1 done", 32'(lk_done), 32'd0);
    rd(8'h08, v); chk("R1 ctrl", v, 32'h0);
    for (int p = 0; p < 3; p++) begin
      rd(8'(8'h40 + 4 * p), v); chk("R1 port state", v, 32'h0);
    end

    // R3 control fields
    wr(8'h08, 32'h8000_0004); rd(8'h08, v); chk("R3 enable+vlan", v, 32'h8000_0004);
    wr(8'h08, 32'h8000_0000); rd(8'h08, v); chk("R3 vlan off", v, 32'h8000_0000);

    // R4 port state registers
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 4; s++) begin
        wr(8'(8'h40 + 4 * p), 32'hFFFF_FFFC | 32'(s));
        rd(8'(8'h40 + 4 * p), v);
        chk("R4 port state readback", v, 32'(s));
      end

    // R2 entry write and read back with reversed word order
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, 32'h1234_5678); wr(8'h3C, 32'h9ABC_DEF0);
    wr(8'h20, 32'h8000_0005);
    put_entry(6, '0);
    get_entry(5, w0, w1, w2);
    chk("R2 word0 top bits", w0, 32'h0000_001F);
    chk("R2 word1", w1, 32'h1234_5678);
    chk("R2 word2", w2, 32'h9ABC_DEF0);
    get_entry(6, w0, w1, w2);
    chk("R2 other entry", w1, 32'h0);

    // R5 clear: fill with address entries, then clear
    for (int i = 0; i < DEPTH; i++) put_entry(i, mk_uc(MAC_A, 1, 0, 2'd1));
    wr(8'h08, 32'hC000_0000);
    rd(8'h08, v);
    chk("R5 clear bit set while running", v, 32'hC000_0000);
    chk("R5 lookup stalled during clear", 32'(lk_ready), 32'd0);
    repeat (DEPTH + 2) @(negedge clk);
    rd(8'h08, v); chk("R5 clear bit self-cleared", v, 32'h8000_0000);
    for (int i = 0; i < DEPTH; i++) begin
      get_entry(i, w0, w1, w2);
      chk("R5 entry type free", w1 & 32'h3000_0000, 32'h0);
    end

    // Table for lookups
    put_entry(1, mk_uc(MAC_A, 2, 0, 2'd1));
    put_entry(2, mk_uc(MAC_B, 1, 1, 2'd3));
    put_entry(3, mk_mc(MAC_C, 3'b101, 2'd1));
    put_entry(4, mk_uc(MAC_D, 1, 0, 2'd2));
    put_entry(5, mk_uc(MAC_E, 0, 0, 2'd3));
    put_entry(6, mk_uc(MAC_E, 2, 0, 2'd1));

    // Sweep of all port-state combinations and sources
    for (int c = 0; c < 64; c++) begin
      fw = '0;
      for (int p = 0; p < 3; p++) begin
        wr(8'(8'h40 + 4 * p), 32'((c >> (2 * p)) & 3));
        fw[p] = (((c >> (2 * p)) & 3) == 3);
      end
      for (int s = 0; s < 3; s++) begin
        lookup(MAC_A, s, m); chk("R6 unicast hit", 32'(m), 32'(exp_mask(1, 2, 3'b0, fw, s)));
        lookup(MAC_B, s, m); chk("R7 blocked unicast", 32'(m), 32'(exp_mask(2, 0, 3'b0, fw, s)));
        lookup(MAC_C, s, m); chk("R8 multicast mask", 32'(m), 32'(exp_mask(3, 0, 3'b101, fw, s)));
        lookup(MAC_D, s, m); chk("R6 vlan-only type ignored", 32'(m), 32'(exp_mask(0, 0, 3'b0, fw, s)));
        lookup(MAC_E, s, m); chk("R11 lowest index wins", 32'(m), 32'(exp_mask(1, 0, 3'b0, fw, s)));
        lookup(MAC_F, s, m); chk("R9 miss floods", 32'(m), 32'(exp_mask(0, 0, 3'b0, fw, s)));
      end
    end

    // R10 disabled engine
    for (int p = 0; p < 3; p++) wr(8'(8'h40 + 4 * p), 32'd3);
    wr(8'h08, 32'h0);
    lookup(MAC_A, 0, m); chk("R10 disabled hit empty", 32'(m), 32'd0);
    lookup(MAC_F, 1, m); chk("R10 disabled miss empty", 32'(m), 32'd0);
    wr(8'h08, 32'h8000_0000);
    lookup(MAC_A, 0, m); chk("R6 re-enabled hit", 32'(m), 32'b100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule